// File: doc/BRIEF.md
# Bilinear Pixel Interpolator with Out-of-Range Fallback

This block blends four neighbouring source pixels into one output pixel. The four pixels form a 2x2 cell (top-left, top-right, bottom-left, bottom-right). Two fractional offsets give the sample point inside that cell, and they set the weights. The offsets typically come from an upstream coordinate-transform stage that has split a source location into an integer part, used to fetch the pixels, and a fractional part, used here.

When the upstream stage marks a sample as lying outside the source image, the block ignores the pixels and returns a grey level supplied on a port. Samples stream through a three-register pipeline. One result can be accepted every cycle, and a valid strobe travels alongside the data.

The blend works along rows first and then down the column. Each fractional step keeps its full precision, and a single round-to-nearest happens at the last stage.

Top module: `bilerp_px`

## Requirements
- R1: A sample presented with `valid_i` high is captured on a rising edge n. Its result is on `pix_o`, with `valid_o` high, after edge n+2. `valid_o` is low in every cycle that has no such result, and back-to-back samples give back-to-back results.
- R2: With `oor_i` low, `S = 2^FRAC_W` and `acc = (S-fx)(S-fy)·tl + fx(S-fy)·tr + (S-fx)fy·bl + fx·fy·br`, the result is `floor((acc + 2^(2·FRAC_W-1)) / 2^(2·FRAC_W))`. Here `fx_i` weights the right-hand column and `fy_i` weights the bottom row, both in units of 1/S.
- R3: With `oor_i` low and both fractions zero, the result equals `tl_i` exactly.
- R4: With `oor_i` high, the result equals the `grey_i` value presented with that sample. The four pixels and both fractions of that sample have no effect on it.
- R5: With `oor_i` low, the result is never below the smallest of the four pixels and never above the largest.
- R6: While `rst_ni` is low, and after its release until the first result, `valid_o` is 0 and `pix_o` is 0.
- R7: `pix_o` keeps its previous value in every cycle in which `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample present this cycle |
| tl_i | input | PIX_W | Top-left pixel |
| tr_i | input | PIX_W | Top-right pixel |
| bl_i | input | PIX_W | Bottom-left pixel |
| br_i | input | PIX_W | Bottom-right pixel |
| fx_i | input | FRAC_W | Horizontal fraction, 0 selects the left column |
| fy_i | input | FRAC_W | Vertical fraction, 0 selects the top row |
| oor_i | input | 1 | Sample lies outside the source image |
| grey_i | input | PIX_W | Fallback level used when `oor_i` is high |
| valid_o | output | 1 | Result present on `pix_o` |
| pix_o | output | PIX_W | Interpolated or fallback pixel |

## Verification
The hardest behaviour to reach from the ports is the rounding boundary. The weighted sum lands exactly on a half step, or sits at the top of the pixel range with both fractions at their maximum. Random pixel values rarely hit either case. The bench therefore shrinks the block to 3-bit pixels and 2-bit fractions and sweeps every combination of the four pixels and both fractions, 65,536 samples in all. Fallback samples and idle cycles are interleaved on co-prime strides, so they also land next to each other and mid-stream, where a pipeline misalignment of the flag or the strobe would show.

// File: rtl/bilerp_px_pkg.sv
package bilerp_px_pkg;
  // width after one lerp step keeps the fraction bits
  function automatic int unsigned row_w(int unsigned pix_w, int unsigned frac_w);
    return pix_w + frac_w;
  endfunction
  // width after both steps, before rounding
  function automatic int unsigned col_w(int unsigned pix_w, int unsigned frac_w);
    return pix_w + 2 * frac_w;
  endfunction
  localparam int unsigned NUM_TAPS = 4;
endpackage

// File: rtl/bilerp_px_lerp.sv
module bilerp_px_lerp #(
  parameter int unsigned IN_W = 8,
  parameter int unsigned FR_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [IN_W-1:0]      a_i,
  input  logic [IN_W-1:0]      b_i,
  input  logic [FR_W-1:0]      f_i,
  output logic [IN_W+FR_W-1:0] y_o
);
  localparam int unsigned OUT_W = IN_W + FR_W;
  localparam int unsigned EXT_W = OUT_W + 2;

  logic signed [EXT_W-1:0] base_x, diff_x, frac_x, sum_x;

  // y = a*2^F + f*(b-a), one multiplier, exact
  always_comb begin
    base_x = $signed({2'b00, a_i, {FR_W{1'b0}}});
    diff_x = EXT_W'($signed({1'b0, b_i})) - EXT_W'($signed({1'b0, a_i}));
    frac_x = EXT_W'($signed({1'b0, f_i}));
    sum_x  = base_x + diff_x * frac_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_o <= '0;
    else if (en_i) y_o <= sum_x[OUT_W-1:0];
  end

  p_lerp_fit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (sum_x[EXT_W-1:OUT_W] == '0));

  p_lerp_between_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((y_o >= {(($past(a_i) < $past(b_i)) ? $past(a_i) : $past(b_i)), {FR_W{1'b0}}}) &&
              (y_o <= {(($past(a_i) > $past(b_i)) ? $past(a_i) : $past(b_i)), {FR_W{1'b0}}})));
endmodule

// File: rtl/bilerp_px_round.sv
module bilerp_px_round #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned FRAC_W = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic [PIX_W+2*FRAC_W-1:0]     v_i,
  output logic [PIX_W-1:0]              pix_o
);
  localparam int unsigned V_W  = PIX_W + 2 * FRAC_W;
  localparam int unsigned SH   = 2 * FRAC_W;
  localparam logic [V_W-1:0] HALF = V_W'(1) << (SH - 1);

  logic [PIX_W-1:0] pix_d;

  // max input plus half still fits V_W bits
  assign pix_d = PIX_W'((v_i + HALF) >> SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pix_o <= '0;
    else if (en_i) pix_o <= pix_d;
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pix_o));
endmodule

// File: rtl/bilerp_px.sv
module bilerp_px #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [PIX_W-1:0]  tl_i,
  input  logic [PIX_W-1:0]  tr_i,
  input  logic [PIX_W-1:0]  bl_i,
  input  logic [PIX_W-1:0]  br_i,
  input  logic [FRAC_W-1:0] fx_i,
  input  logic [FRAC_W-1:0] fy_i,
  input  logic              oor_i,
  input  logic [PIX_W-1:0]  grey_i,
  output logic              valid_o,
  output logic [PIX_W-1:0]  pix_o
);
  import bilerp_px_pkg::*;

  localparam int unsigned H_W   = row_w(PIX_W, FRAC_W);
  localparam int unsigned V_W   = col_w(PIX_W, FRAC_W);
  localparam int unsigned DEPTH = 3;

  logic [PIX_W-1:0]  tap [NUM_TAPS];
  logic [H_W-1:0]    row_q [2];
  logic [V_W-1:0]    col_q;
  logic [FRAC_W-1:0] fy_q;
  logic [DEPTH-1:0]  vld_q;

  // fallback: flatten the cell to grey, any lerp of it returns grey exactly
  always_comb begin
    tap[0] = oor_i ? grey_i : tl_i;
    tap[1] = oor_i ? grey_i : tr_i;
    tap[2] = oor_i ? grey_i : bl_i;
    tap[3] = oor_i ? grey_i : br_i;
  end

  for (genvar r = 0; r < 2; r++) begin : g_row
    bilerp_px_lerp #(.IN_W(PIX_W), .FR_W(FRAC_W)) u_row (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (valid_i),
      .a_i    (tap[2*r]),
      .b_i    (tap[2*r+1]),
      .f_i    (fx_i),
      .y_o    (row_q[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fy_q  <= '0;
      vld_q <= '0;
    end else begin
      if (valid_i) fy_q <= fy_i;
      vld_q <= {vld_q[DEPTH-2:0], valid_i};
    end
  end

  bilerp_px_lerp #(.IN_W(H_W), .FR_W(FRAC_W)) u_col (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (vld_q[0]),
    .a_i    (row_q[0]),
    .b_i    (row_q[1]),
    .f_i    (fy_q),
    .y_o    (col_q)
  );

  bilerp_px_round #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_round (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (vld_q[1]),
    .v_i    (col_q),
    .pix_o  (pix_o)
  );

  assign valid_o = vld_q[DEPTH-1];

  // cycles since reset, saturating, keeps $past inside the post-reset window
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  function automatic logic [PIX_W-1:0] min4(logic [PIX_W-1:0] a, logic [PIX_W-1:0] b,
                                            logic [PIX_W-1:0] c, logic [PIX_W-1:0] d);
    logic [PIX_W-1:0] m0, m1;
    m0 = (a < b) ? a : b;
    m1 = (c < d) ? c : d;
    return (m0 < m1) ? m0 : m1;
  endfunction

  function automatic logic [PIX_W-1:0] max4(logic [PIX_W-1:0] a, logic [PIX_W-1:0] b,
                                            logic [PIX_W-1:0] c, logic [PIX_W-1:0] d);
    logic [PIX_W-1:0] m0, m1;
    m0 = (a > b) ? a : b;
    m1 = (c > d) ? c : d;
    return (m0 > m1) ? m0 : m1;
  endfunction

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  p_zero_frac_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && $past(valid_i, 3) && !$past(oor_i, 3) &&
     ($past(fx_i, 3) == '0) && ($past(fy_i, 3) == '0)) |-> (pix_o == $past(tl_i, 3)));

  p_grey_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && $past(valid_i, 3) && $past(oor_i, 3)) |-> (pix_o == $past(grey_i, 3)));

  p_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && $past(valid_i, 3) && !$past(oor_i, 3)) |->
      ((pix_o >= min4($past(tl_i, 3), $past(tr_i, 3), $past(bl_i, 3), $past(br_i, 3))) &&
       (pix_o <= max4($past(tl_i, 3), $past(tr_i, 3), $past(bl_i, 3), $past(br_i, 3)))));
endmodule

// File: tb/bilerp_px_tb.sv
module bilerp_px_tb;
  localparam int PW = 3;
  localparam int FW = 2;
  localparam int NVEC = 1 << (4 * PW + 2 * FW);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [PW-1:0] tl_i = '0, tr_i = '0, bl_i = '0, br_i = '0, grey_i = '0;
  logic [FW-1:0] fx_i = '0, fy_i = '0;
  logic          oor_i = 1'b0;
  logic          valid_o;
  logic [PW-1:0] pix_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int    q_vld [3];
  int    q_exp [3];
  int    q_lo  [3];
  int    q_hi  [3];
  int    q_oor [3];
  string q_tag [3];
  int    last_pix = 0;

  always #10 clk_i = ~clk_i;

  bilerp_px #(.PIX_W(PW), .FRAC_W(FW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .tl_i(tl_i), .tr_i(tr_i), .bl_i(bl_i), .br_i(br_i),
    .fx_i(fx_i), .fy_i(fy_i), .oor_i(oor_i), .grey_i(grey_i),
    .valid_o(valid_o), .pix_o(pix_o)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model(int tl, int tr, int bl, int br, int fx, int fy);
    int s, acc;
    s   = 1 << FW;
    acc = (s - fx) * (s - fy) * tl + fx * (s - fy) * tr + (s - fx) * fy * bl + fx * fy * br;
    return (acc + (1 << (2 * FW - 1))) >> (2 * FW);
  endfunction

  task automatic compare_cycle();
    check("R1 valid_o", int'(valid_o), q_vld[2]);
    if (q_vld[2] != 0) begin
      check(q_tag[2], int'(pix_o), q_exp[2]);
      if (q_oor[2] == 0)
        check("R5 in range", ((int'(pix_o) >= q_lo[2]) && (int'(pix_o) <= q_hi[2])) ? 1 : 0, 1);
      last_pix = q_exp[2];
    end else begin
      check("R7 hold", int'(pix_o), last_pix);
    end
  endtask

  task automatic drive(int i);
    int a, b, c, d, fx, fy;
    a = i & 7; b = (i >> 3) & 7; c = (i >> 6) & 7; d = (i >> 9) & 7;
    fx = (i >> 12) & 3; fy = (i >> 14) & 3;
    tl_i = PW'(a); tr_i = PW'(b); bl_i = PW'(c); br_i = PW'(d);
    fx_i = FW'(fx); fy_i = FW'(fy);
    valid_i = ((i % 11) != 10);
    oor_i   = ((i % 13) == 5);
    grey_i  = PW'((i * 5) % 8);
    q_vld[0] = valid_i ? 1 : 0;
    q_oor[0] = oor_i ? 1 : 0;
    q_lo[0]  = a; q_hi[0] = a;
    if (b < q_lo[0]) q_lo[0] = b;
    if (c < q_lo[0]) q_lo[0] = c;
    if (d < q_lo[0]) q_lo[0] = d;
    if (b > q_hi[0]) q_hi[0] = b;
    if (c > q_hi[0]) q_hi[0] = c;
    if (d > q_hi[0]) q_hi[0] = d;
    if (oor_i) begin
      q_exp[0] = (i * 5) % 8;
      q_tag[0] = "R4 grey";
    end else if (fx == 0 && fy == 0) begin
      q_exp[0] = a;
      q_tag[0] = "R3 zero fraction";
    end else begin
      q_exp[0] = model(a, b, c, d, fx, fy);
      q_tag[0] = "R2 blend";
    end
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin
      q_vld[k] = 0; q_exp[k] = 0; q_lo[k] = 0; q_hi[k] = 0; q_oor[k] = 0; q_tag[k] = "R2";
    end
    repeat (3) @(negedge clk_i);
    check("R6 valid_o in reset", int'(valid_o), 0);
    check("R6 pix_o in reset", int'(pix_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R6 valid_o after reset", int'(valid_o), 0);
    check("R6 pix_o after reset", int'(pix_o), 0);
    for (int i = 0; i < NVEC + 4; i++) begin
      @(negedge clk_i);
      compare_cycle();
      for (int k = 2; k > 0; k--) begin
        q_vld[k] = q_vld[k-1]; q_exp[k] = q_exp[k-1]; q_lo[k] = q_lo[k-1];
        q_hi[k]  = q_hi[k-1];  q_oor[k] = q_oor[k-1]; q_tag[k] = q_tag[k-1];
      end
      if (i < NVEC) begin
        drive(i);
      end else begin
        valid_i  = 1'b0;
        q_vld[0] = 0;
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule